// File: doc/BRIEF.md
# Lane Request Coalescer

This block sits between a group of sixteen parallel lanes and a memory port. Each request carries one byte address per lane, a mask of the lanes taking part, an access-width code and a rule selector. The block groups those addresses into aligned memory transactions and emits them one per cycle. The aim is to issue as few transactions as the selected rule set allows. Data movement is not handled here: only addresses, segment lengths and a transaction count leave the block.

Two rule sets are available. The strict rule issues a minimal set of transactions only when lane k targets word k of one aligned footprint. Any other pattern makes it issue one transaction per active lane. The relaxed rule accepts any pattern and issues one transaction per distinct aligned segment the active lanes touch. It also narrows a segment whenever the lanes it serves all sit in one aligned half of it.

Top module: `coal_unit`

## Requirements
- R1: `req_ready` is high exactly when no transactions of an earlier request are pending. A request is taken on a cycle with `req_valid` and `req_ready` both high. After a request with a non-zero mask is taken, `req_ready` stays low until the cycle in which `done` is high.
- R2: The width code on `req_size` selects the word size: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes, 3 gives 8 bytes and 4 gives 16 bytes. It also selects the segment size: 32 bytes for code 0, 64 bytes for code 1, and 128 bytes for codes 2 to 4. Address bits below the word size are ignored.
- R3: In strict mode (`req_relaxed` = 0), a request is in order when every active lane k addresses base + k·W (W = word size) and base is a multiple of 16·W. Inactive lanes do not break this. Such a request issues one transaction per segment touched: one for codes 0 to 3, and two for code 4 with all lanes active. Each transaction's `tx_addr` is segment-aligned and its `tx_len` equals the segment size.
- R4: In strict mode, a request that is not in order issues one transaction per active lane, in ascending lane order. Each has `tx_addr` equal to the lane's word-aligned address and `tx_len` equal to W.
- R5: In relaxed mode (`req_relaxed` = 1), the block issues one transaction per distinct aligned segment holding at least one active lane's word. These come in strictly ascending address order.
- R6: In relaxed mode, a segment larger than 32 bytes is halved, repeatedly down to 32 bytes, while all the words it serves lie in one aligned half. `tx_len` is therefore always 32, 64 or 128, and `tx_addr` is aligned to `tx_len`.
- R7: A request with an all-zero mask issues no transaction. `done` is high in the cycle right after it is taken, and `tx_count` reads 0.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_addr` and `tx_len` hold their values into the next cycle.
- R9: `done` is a one-cycle pulse in the cycle after the last transaction handshake. At that point `tx_count` equals the number of transactions issued, and it holds until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | LANES·AW | Byte address per lane, lane k in bits [k·AW +: AW] |
| req_mask | input | LANES | Active lane mask, bit k for lane k |
| req_size | input | 3 | Word width code (0..4) |
| req_relaxed | input | 1 | 0 strict rule, 1 relaxed rule |
| tx_valid | output | 1 | A transaction is presented |
| tx_ready | input | 1 | Memory side takes the transaction |
| tx_addr | output | AW | Aligned transaction base address |
| tx_len | output | 8 | Transaction length in bytes |
| done | output | 1 | One-cycle pulse when a request has finished |
| tx_count | output | $clog2(LANES+1) | Transactions issued for the last request |

## Verification
A request is registered on the accepting edge. Its first transaction is therefore visible on the outputs in the cycle after that edge. Each later transaction appears in the cycle after the handshake edge that retired the one before it. `done` and the final `tx_count` arrive in the cycle after the last handshake, or in the cycle right after acceptance when the mask is zero. The bench drives and samples on falling edges. It counts handshakes against an arithmetically computed transaction list, and checks `done`, `tx_count` and `req_ready` exactly one falling edge after the edge that should produce them. It also checks that `done` has dropped one edge later.

// File: rtl/coal_pkg.sv
package coal_pkg;
   localparam int MIN_SEG_SH  = 5;
   localparam int MAX_SEG_SH  = 7;
   localparam int MAX_WORD_SH = 4;

   // log2 of the word size in bytes; codes above the widest one clamp
   function automatic logic [2:0] word_shift(input logic [2:0] code);
      return (code > 3'(MAX_WORD_SH)) ? 3'(MAX_WORD_SH) : code;
   endfunction

   // log2 of the grouping segment in bytes
   function automatic logic [2:0] seg_shift(input logic [2:0] code);
      case (code)
         3'd0:    return 3'(MIN_SEG_SH);
         3'd1:    return 3'(MIN_SEG_SH + 1);
         default: return 3'(MAX_SEG_SH);
      endcase
   endfunction
endpackage

// File: rtl/coal_strict.sv
module coal_strict #(
   parameter int LANES = 16,
   parameter int AW    = 32
) (
   input  logic [LANES*AW-1:0] lane_addr,
   input  logic [LANES-1:0]    lane_mask,
   input  logic [2:0]          wsh,
   output logic                in_order
);
   localparam int LB = $clog2(LANES);

   logic [AW-1:0] addr_w [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign addr_w[g] = lane_addr[g*AW +: AW];
   end

   always_comb begin
      logic          ref_seen;
      logic [AW-1:0] ref_hi;
      logic [AW-1:0] off_mask;
      int            fsh;
      ref_seen = 1'b0;
      ref_hi   = '0;
      in_order = 1'b1;
      fsh      = int'(wsh) + LB;
      off_mask = (AW'(1) << fsh) - AW'(1);
      for (int i = 0; i < LANES; i++) begin
         if (lane_mask[i]) begin
            if (!ref_seen) begin
               ref_seen = 1'b1;
               ref_hi   = addr_w[i] >> fsh;
            end
            if ((addr_w[i] & off_mask) != (AW'(i) << wsh)) in_order = 1'b0;
            if ((addr_w[i] >> fsh) != ref_hi)               in_order = 1'b0;
         end
      end
   end
endmodule

// File: rtl/coal_pick.sv
module coal_pick
   import coal_pkg::*;
#(
   parameter int LANES = 16,
   parameter int AW    = 32
) (
   input  logic [LANES*AW-1:0] lane_addr,
   input  logic [LANES-1:0]    pend,
   input  logic [2:0]          wsh,
   input  logic [2:0]          ssh,
   input  logic                group,
   input  logic                shrink,
   output logic [LANES-1:0]    take,
   output logic [AW-1:0]       tx_addr,
   output logic [7:0]          tx_len
);
   localparam int LW = $clog2(LANES);

   logic [AW-1:0] addr_w [LANES];
   logic [AW-1:0] key    [LANES];
   logic [AW-1:0] best_key;
   logic [LW-1:0] best_lane;
   logic [AW-1:0] seg_base;
   logic [2:0]    len_sh;

   for (genvar g = 0; g < LANES; g++) begin : g_key
      assign addr_w[g] = lane_addr[g*AW +: AW];
      assign key[g]    = addr_w[g] >> ssh;
   end

   // lowest segment key among pending lanes, or lowest pending lane
   always_comb begin
      logic found;
      found     = 1'b0;
      best_key  = '0;
      best_lane = '0;
      for (int i = 0; i < LANES; i++) begin
         if (pend[i] && (!found || (group && (key[i] < best_key)))) begin
            found     = 1'b1;
            best_key  = key[i];
            best_lane = LW'(i);
         end
      end
   end

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         take[i] = pend[i] && (group ? (key[i] == best_key) : (best_lane == LW'(i)));
      end
   end

   // narrow the segment while every served word stays in one aligned half
   always_comb begin
      logic keep;
      logic any1;
      logic any0;
      seg_base = best_key << ssh;
      len_sh   = ssh;
      keep     = shrink;
      for (int b = MAX_SEG_SH - 1; b >= MIN_SEG_SH; b--) begin
         any1 = 1'b0;
         any0 = 1'b0;
         for (int i = 0; i < LANES; i++) begin
            if (take[i]) begin
               if (addr_w[i][b]) any1 = 1'b1;
               else              any0 = 1'b1;
            end
         end
         if (b < int'(ssh)) begin
            if (keep && !(any1 && any0)) begin
               len_sh      = 3'(b);
               seg_base[b] = any1;
            end else begin
               keep = 1'b0;
            end
         end
      end
   end

   assign tx_addr = group ? seg_base : addr_w[best_lane];
   assign tx_len  = 8'(1) << (group ? len_sh : wsh);
endmodule

// File: rtl/coal_unit.sv
module coal_unit
   import coal_pkg::*;
#(
   parameter int LANES = 16,
   parameter int AW    = 32,
   localparam int CW   = $clog2(LANES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [LANES*AW-1:0] req_addr,
   input  logic [LANES-1:0]    req_mask,
   input  logic [2:0]          req_size,
   input  logic                req_relaxed,
   output logic                tx_valid,
   input  logic                tx_ready,
   output logic [AW-1:0]       tx_addr,
   output logic [7:0]          tx_len,
   output logic                done,
   output logic [CW-1:0]       tx_count
);
   initial begin
      assert (LANES >= 2 && (LANES & (LANES - 1)) == 0)
         else $error("coal_unit: LANES must be a power of two, at least 2");
      assert (AW > MAX_SEG_SH + 1)
         else $error("coal_unit: AW too narrow for the segment sizes");
   end

   logic [2:0]          in_wsh;
   logic [2:0]          in_ssh;
   logic [LANES*AW-1:0] in_al;
   logic                strict_ok;

   logic [LANES*AW-1:0] lane_q;
   logic [LANES-1:0]    pend_q;
   logic [2:0]          wsh_q;
   logic [2:0]          ssh_q;
   logic                relaxed_q;
   logic                group_q;
   logic                done_q;
   logic [CW-1:0]       cnt_q;
   logic [LANES-1:0]    take;
   logic                accept;
   logic                fire;

   assign in_wsh = word_shift(req_size);
   assign in_ssh = seg_shift(req_size);

   for (genvar g = 0; g < LANES; g++) begin : g_align
      assign in_al[g*AW +: AW] = req_addr[g*AW +: AW] & ~((AW'(1) << in_wsh) - AW'(1));
   end

   coal_strict #(.LANES(LANES), .AW(AW)) u_strict (
      .lane_addr (in_al),
      .lane_mask (req_mask),
      .wsh       (in_wsh),
      .in_order  (strict_ok)
   );

   coal_pick #(.LANES(LANES), .AW(AW)) u_pick (
      .lane_addr (lane_q),
      .pend      (pend_q),
      .wsh       (wsh_q),
      .ssh       (ssh_q),
      .group     (group_q),
      .shrink    (relaxed_q),
      .take      (take),
      .tx_addr   (tx_addr),
      .tx_len    (tx_len)
   );

   assign req_ready = (pend_q == '0);
   assign tx_valid  = (pend_q != '0);
   assign accept    = req_valid && req_ready;
   assign fire      = tx_valid && tx_ready;
   assign done      = done_q;
   assign tx_count  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_q    <= '0;
         pend_q    <= '0;
         wsh_q     <= '0;
         ssh_q     <= 3'(MIN_SEG_SH);
         relaxed_q <= 1'b0;
         group_q   <= 1'b0;
         done_q    <= 1'b0;
         cnt_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            lane_q    <= in_al;
            pend_q    <= req_mask;
            wsh_q     <= in_wsh;
            ssh_q     <= in_ssh;
            relaxed_q <= req_relaxed;
            group_q   <= req_relaxed || strict_ok;
            cnt_q     <= '0;
            done_q    <= (req_mask == '0);
         end else if (fire) begin
            pend_q <= pend_q & ~take;
            cnt_q  <= cnt_q + CW'(1);
            done_q <= ((pend_q & ~take) == '0);
         end
      end
   end

   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_mask != '0) |=> !req_ready) else $error("busy accept"); // R1
   AST_STRICT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !relaxed_q && !group_q) |-> (tx_len == (8'(1) << wsh_q))) else $error("lane len"); // R4
   AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && group_q) |=> (!tx_valid || tx_addr > $past(tx_addr))) else $error("order"); // R5
   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && relaxed_q) |-> ((tx_len == 8'd32 || tx_len == 8'd64 || tx_len == 8'd128)
                                   && ((tx_addr & AW'(tx_len - 8'd1)) == '0))) else $error("len"); // R6
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_addr) && $stable(tx_len))) else $error("hold"); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("pulse"); // R9
   AST_NO_TX_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!tx_valid && tx_count <= CW'(LANES))) else $error("done state"); // R9
endmodule

// File: tb/sim_coal_unit.sv
`timescale 1ns/1ps
module sim_coal_unit;
   localparam int LANES = 16;
   localparam int AW    = 32;
   localparam int CW    = $clog2(LANES + 1);

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid = 1'b0;
   logic                req_ready;
   logic [LANES*AW-1:0] req_addr = '0;
   logic [LANES-1:0]    req_mask = '0;
   logic [2:0]          req_size = '0;
   logic                req_relaxed = 1'b0;
   logic                tx_valid;
   logic                tx_ready = 1'b0;
   logic [AW-1:0]       tx_addr;
   logic [7:0]          tx_len;
   logic                done;
   logic [CW-1:0]       tx_count;

   always #2 clk = ~clk;

   coal_unit #(.LANES(LANES), .AW(AW)) u0 (.*);

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] a_in [LANES];
   logic [15:0] mk;
   int          sz;
   bit          rlx;
   longint      exp_addr [LANES*2];
   longint      exp_len  [LANES*2];
   int          exp_n;
   bit          m_in_order;

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic push(input longint ad, input longint ln);
      exp_addr[exp_n] = ad;
      exp_len[exp_n]  = ln;
      exp_n++;
   endtask

   task automatic build_exp();
      longint w, seg, base, s, last, lo, hi, st, len;
      longint al [LANES];
      int     f;
      bit     have, started;
      w   = longint'(1) << sz;
      seg = (sz == 0) ? 32 : (sz == 1) ? 64 : 128;
      for (int k = 0; k < LANES; k++) al[k] = longint'(a_in[k]) & ~(w - 1);
      exp_n = 0;
      f = -1;
      for (int k = 0; k < LANES; k++) if (mk[k] && f < 0) f = k;
      m_in_order = 1'b1;
      if (f >= 0) begin
         base = al[f] - f * w;
         if (base < 0 || (base % (16 * w)) != 0) m_in_order = 1'b0;
         for (int k = 0; k < LANES; k++)
            if (mk[k] && al[k] != base + k * w) m_in_order = 1'b0;
      end
      if (!rlx && !m_in_order) begin
         for (int k = 0; k < LANES; k++) if (mk[k]) push(al[k], w);
      end else begin
         started = 1'b0;
         last = 0;
         while (1) begin
            have = 1'b0;
            s = 0;
            for (int k = 0; k < LANES; k++) begin
               if (mk[k]) begin
                  longint c;
                  c = (al[k] / seg) * seg;
                  if ((!started || c > last) && (!have || c < s)) begin
                     s = c;
                     have = 1'b1;
                  end
               end
            end
            if (!have) break;
            started = 1'b1;
            last = s;
            st = s;
            len = seg;
            if (rlx) begin
               lo = s + seg;
               hi = s;
               for (int k = 0; k < LANES; k++) begin
                  if (mk[k] && (al[k] / seg) * seg == s) begin
                     if (al[k] < lo) lo = al[k];
                     if (al[k] + w - 1 > hi) hi = al[k] + w - 1;
                  end
               end
               while (len > 32) begin
                  if (hi < st + len / 2) len = len / 2;
                  else if (lo >= st + len / 2) begin
                     st = st + len / 2;
                     len = len / 2;
                  end else break;
               end
            end
            push(st, len);
         end
      end
   endtask

   task automatic set_pattern(input int p);
      longint b, w;
      w = longint'(1) << sz;
      b = 32'h0001_0000 * (sz + 1) + 32'h1000 * p;
      mk = 16'hFFFF;
      for (int k = 0; k < LANES; k++) begin
         case (p)
            1:       a_in[k] = 32'(b + (k + 1) * w);
            2:       a_in[k] = 32'(b + ((k == 0) ? 1 : (k == 1) ? 0 : k) * w);
            3:       a_in[k] = 32'(b + 2 * k * w);
            5:       a_in[k] = 32'(b + ((k * 7) % 16) * w * 3);
            7:       a_in[k] = 32'(b + (15 - k) * w);
            8:       a_in[k] = 32'(b + 96 + (k % 2) * w);
            9:       a_in[k] = 32'(b + k * w + ((w > 1) ? (k % w) : 0));
            default: a_in[k] = 32'(b + k * w);
         endcase
      end
      if (p == 4) mk = 16'h5A5A;
      if (p == 6) mk = 16'h0000;
   endtask

   task automatic run_req(input int ridx);
      string tag;
      int    i, cyc;
      bit    rdy, prev_stall;
      longint prev_a;
      build_exp();
      if (rlx)             tag = "R5 R6 R2";
      else if (m_in_order) tag = "R3 R2";
      else                 tag = "R4 R2";
      @(negedge clk);
      for (int k = 0; k < LANES; k++) req_addr[k*AW +: AW] = a_in[k];
      req_mask    = mk;
      req_size    = 3'(sz);
      req_relaxed = rlx;
      req_valid   = 1'b1;
      tx_ready    = 1'b0;
      chk(req_ready == 1'b1, "R1 ready before accept", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      if (exp_n == 0) begin
         chk(done == 1'b1, "R7 done after empty request", done, 1);
         chk(tx_valid == 1'b0, "R7 no transaction", tx_valid, 0);
         chk(tx_count == 0, "R7 count zero", tx_count, 0);
      end else begin
         i = 0;
         cyc = 0;
         prev_stall = 1'b0;
         prev_a = 0;
         while (1) begin
            case (ridx % 3)
               0:       rdy = 1'b1;
               1:       rdy = (cyc % 2) == 1;
               default: rdy = (cyc % 3) != 2;
            endcase
            tx_ready = rdy;
            chk(req_ready == 1'b0, "R1 busy", req_ready, 0);
            if (!tx_valid) begin
               chk(1'b0, {tag, " early end"}, i, exp_n);
               break;
            end
            if (prev_stall) chk(longint'(tx_addr) == prev_a, "R8 hold", tx_addr, prev_a);
            chk(longint'(tx_addr) == exp_addr[i], {tag, " addr"}, tx_addr, exp_addr[i]);
            chk(longint'(tx_len) == exp_len[i], {tag, " len"}, tx_len, exp_len[i]);
            prev_stall = !rdy;
            prev_a = longint'(tx_addr);
            if (rdy) i++;
            @(negedge clk);
            cyc++;
            if (i == exp_n) break;
            if (cyc > 300) begin
               chk(1'b0, "R9 stuck", i, exp_n);
               break;
            end
         end
         tx_ready = 1'b0;
         chk(done == 1'b1, "R9 done after last", done, 1);
         chk(tx_count == CW'(exp_n), "R9 count", tx_count, exp_n);
         chk(tx_valid == 1'b0, "R9 idle at done", tx_valid, 0);
         chk(req_ready == 1'b1, "R1 ready at done", req_ready, 1);
      end
      @(negedge clk);
      chk(done == 1'b0, "R9 pulse ends", done, 0);
      chk(tx_count == CW'(exp_n), "R9 count held", tx_count, exp_n);
   endtask

   initial begin
      int ridx;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
      chk(tx_valid == 1'b0, "R8 reset idle", tx_valid, 0);
      chk(done == 1'b0, "R9 reset done", done, 0);
      chk(tx_count == 0, "R9 reset count", tx_count, 0);
      ridx = 0;
      for (int s = 0; s < 5; s++) begin
         for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 10; p++) begin
               sz = s;
               rlx = (m == 1);
               set_pattern(p);
               run_req(ridx);
               ridx++;
            end
         end
      end
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule